// File: doc/BRIEF.md
# Double-Buffered Timer Period and Compare Core

This block is a 16-bit timer counter with one period register and one compare channel. Software never writes the period or the compare value directly. It writes a buffer register instead, and a per-buffer pending flag records that a new value is waiting. The waiting value is copied into the active register only at the bottom of the counting cycle. A period or duty change therefore never cuts short or stretches the cycle already running. Software can also force the pending period in straight away with an update command.

The counter runs in one of two modes. In single-slope mode it ramps from zero up to the period and wraps to zero. In dual-slope mode it ramps up to the period, stays there for one clock, ramps down to zero, stays there for one clock, and ramps up again. A direct counter load and a restart command can take over the count at any time. The outputs are the count, a one-cycle overflow pulse at each bottom, a waveform bit driven by compare matches, and the two pending flags.

Top module: `dbuf_timer`

## Requirements
- R1: After a synchronous active-low reset, count, ovf, wave, per_valid and cmp_valid are 0, the active period is all ones (0xFFFF) and the active compare value is 0.
- R2: A buffer write sets that buffer's valid flag on the next edge. The flag clears when the buffer is copied. If a write falls on the same edge as a copy, the old buffer value is copied, the new value stays buffered and the flag stays set.
- R3: With dual_slope = 0 and run = 1, each edge steps count by +1 while count < P (the active period). An edge with count >= P sets count to 0 and raises ovf for exactly the following cycle.
- R4: With dual_slope = 1 and P > 0, count runs 0,1..P,P-1..1,0,1.. with each extreme held for one clock. The edge that leaves 0 while counting down raises ovf for the following cycle, in which count is 1. With P = 0, count stays 0 and ovf stays high.
- R5: At each bottom edge (the wrap in R3, the downward turn at 0 in R4) a buffer whose valid flag is set is copied into its active register, taking effect from the next cycle. A buffer whose flag is clear leaves the active value unchanged.
- R6: When cnt_wr = 1, the next count is cnt_data, whatever run, restart or the wrap state are. That edge gives no ovf, no transfer and no change of direction.
- R7: When restart = 1 and cnt_wr = 0, the next count is 0 and the next dual-slope step is upward.
- R8: upd_cmd = 1 copies a set period buffer into the active period on that edge and clears per_valid. It has no effect on the compare buffer or on cmp_valid.
- R9: With dual_slope = 0, a counting edge with count == C (the active compare) sets wave, and a wrap edge clears it. When both occur on the same edge, the clear wins. In steady state, wave equals (count > C).
- R10: With dual_slope = 1, wave toggles on every counting edge with count == C.
- R11: With run = 0, cnt_wr = 0 and restart = 0, count and wave hold, ovf is 0 and no transfer takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Count enable |
| dual_slope | input | 1 | 0 = single-slope, 1 = dual-slope |
| per_buf_wr | input | 1 | Write strobe for the period buffer |
| per_buf_data | input | 16 | Period buffer write data |
| cmp_buf_wr | input | 1 | Write strobe for the compare buffer |
| cmp_buf_data | input | 16 | Compare buffer write data |
| upd_cmd | input | 1 | Immediate period update command |
| cnt_wr | input | 1 | Direct counter write strobe |
| cnt_data | input | 16 | Direct counter write data |
| restart | input | 1 | Force-restart command |
| count | output | 16 | Current counter value |
| ovf | output | 1 | One-cycle pulse after each bottom edge |
| wave | output | 1 | Compare waveform bit |
| per_valid | output | 1 | Period buffer holds an untransferred value |
| cmp_valid | output | 1 | Compare buffer holds an untransferred value |

## Verification
Suppose an active register picks up its buffer at the wrong edge, or a valid flag fails to clear. The wrap point, or the count at which wave rises, moves within one period, and the flag stays visibly set after the bottom edge. A lost direction or a mis-sized extreme shows at once as a count that steps by more than one, or repeats a value, against an arithmetic ramp. A faulty priority among counter load, restart and counting shows on the very next cycle as a wrong count or a spurious ovf. The sweeps cover every period and compare pairing in a small range, in both modes, so a slip at any boundary shows within a few periods.

// File: rtl/dbuf_timer_pkg.sv
// Package: shared types for the double-buffered timer.
// Assumes: nothing beyond standard SystemVerilog.
package dbuf_timer_pkg;

    // Direction of the dual-slope ramp; single-slope always uses DIR_UP.
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    // Index of each buffered channel inside the shadow array.
    localparam int CH_PER = 0;
    localparam int CH_CMP = 1;
    localparam int N_CH   = 2;

endpackage

// File: rtl/dbuf_timer_shadow.sv
// Module: one buffered register (buffer, valid flag and active copy).
// The buffer takes each write and sets the flag. On a load strobe with the
// flag set, the buffer is copied into the active register and the flag
// clears, unless a write lands on the same edge. Then the old buffer
// value is copied and the flag stays set.
// Assumes: load is a single-cycle strobe from the owning control logic.
module dbuf_timer_shadow #(
    parameter int           W       = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         load,
    output logic [W-1:0] active,
    output logic         valid
);

    logic [W-1:0] buf_q;
    logic         take;

    // Copy only when something is pending.
    assign take = load && valid;

    // Buffer, flag and active register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q  <= '0;
            active <= RST_VAL;
            valid  <= 1'b0;
        end else begin
            if (take) begin
                active <= buf_q;
            end
            if (wr) begin
                buf_q <= wdata;
                valid <= 1'b1;
            end else if (take) begin
                valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dbuf_timer_count.sv
// Module: counter core with single- and dual-slope ramps.
// The priority order is: direct write, then restart, then counting.
// bottom_evt marks a counting edge that wraps (single-slope) or turns up
// from zero (dual-slope). match_evt marks a counting edge at the compare
// value. ovf is bottom_evt registered.
// Assumes: per and cmp are stable active values from the shadow registers.
module dbuf_timer_count
    import dbuf_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         dual_slope,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_data,
    input  logic         restart,
    input  logic [W-1:0] per,
    input  logic [W-1:0] cmp,
    output logic [W-1:0] count,
    output logic         bottom_evt,
    output logic         match_evt,
    output logic         ovf
);

    localparam logic [W-1:0] ONE = W'(1);

    dir_e         dir_q;
    dir_e         dir_nxt;
    logic [W-1:0] cnt_nxt;
    logic         counting;
    logic         at_top;
    logic         at_zero;
    logic         per_zero;

    assign counting  = run && !cnt_wr && !restart;
    assign at_top    = (count >= per);
    assign at_zero   = (count == '0);
    assign per_zero  = (per == '0);
    assign match_evt = counting && (count == cmp);

    // Next count, next direction and bottom detection for a counting edge.
    always_comb begin
        cnt_nxt    = count;
        dir_nxt    = dir_q;
        bottom_evt = 1'b0;
        if (counting) begin
            if (!dual_slope) begin
                dir_nxt = DIR_UP;
                if (at_top) begin
                    cnt_nxt    = '0;
                    bottom_evt = 1'b1;
                end else begin
                    cnt_nxt = count + ONE;
                end
            end else if (per_zero) begin
                cnt_nxt    = '0;
                dir_nxt    = DIR_UP;
                bottom_evt = 1'b1;
            end else if (dir_q == DIR_UP) begin
                if (at_top) begin
                    cnt_nxt = count - ONE;
                    dir_nxt = DIR_DOWN;
                end else begin
                    cnt_nxt = count + ONE;
                end
            end else begin
                if (at_zero) begin
                    cnt_nxt    = ONE;
                    dir_nxt    = DIR_UP;
                    bottom_evt = 1'b1;
                end else begin
                    cnt_nxt = count - ONE;
                end
            end
        end
    end

    // Counter and direction registers with write/restart priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            dir_q <= DIR_UP;
        end else if (cnt_wr) begin
            count <= cnt_data;
        end else if (restart) begin
            count <= '0;
            dir_q <= DIR_UP;
        end else begin
            count <= cnt_nxt;
            dir_q <= dir_nxt;
        end
    end

    // Overflow pulse, one cycle after each bottom edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else begin
            ovf <= bottom_evt;
        end
    end

endmodule

// File: rtl/dbuf_timer_wave.sv
// Module: compare waveform generator.
// Single-slope: set on match, clear on wrap, clear wins on a tie.
// Dual-slope: toggle on every match.
// Assumes: match_evt and bottom_evt only pulse on counting edges.
module dbuf_timer_wave (
    input  logic clk,
    input  logic rst_n,
    input  logic dual_slope,
    input  logic bottom_evt,
    input  logic match_evt,
    output logic wave
);

    // Waveform register update per mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave <= 1'b0;
        end else if (dual_slope) begin
            if (match_evt) begin
                wave <= !wave;
            end
        end else if (bottom_evt) begin
            wave <= 1'b0;
        end else if (match_evt) begin
            wave <= 1'b1;
        end
    end

endmodule

// File: rtl/dbuf_timer.sv
// Module: double-buffered 16-bit timer top.
// Combines the period and compare shadow registers (built in a generate
// loop), the counter core and the waveform generator. A bottom edge loads
// both buffers. upd_cmd also loads the period buffer.
// Assumes: all inputs are synchronous to clk.
module dbuf_timer
    import dbuf_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         dual_slope,
    input  logic         per_buf_wr,
    input  logic [W-1:0] per_buf_data,
    input  logic         cmp_buf_wr,
    input  logic [W-1:0] cmp_buf_data,
    input  logic         upd_cmd,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_data,
    input  logic         restart,
    output logic [W-1:0] count,
    output logic         ovf,
    output logic         wave,
    output logic         per_valid,
    output logic         cmp_valid
);

    localparam logic [W-1:0] PER_INIT = {W{1'b1}};
    localparam logic [W-1:0] CMP_INIT = {W{1'b0}};

    logic [N_CH-1:0] sh_wr;
    logic [N_CH-1:0] sh_ld;
    logic [N_CH-1:0] sh_vld;
    logic [W-1:0]    sh_wdata [N_CH];
    logic [W-1:0]    sh_act   [N_CH];
    logic            bottom_evt;
    logic            match_evt;

    // Route channel strobes and data into the shadow array.
    always_comb begin
        sh_wr[CH_PER]    = per_buf_wr;
        sh_wr[CH_CMP]    = cmp_buf_wr;
        sh_wdata[CH_PER] = per_buf_data;
        sh_wdata[CH_CMP] = cmp_buf_data;
        sh_ld[CH_PER]    = bottom_evt || upd_cmd;
        sh_ld[CH_CMP]    = bottom_evt;
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_shadow
        dbuf_timer_shadow #(
            .W       (W),
            .RST_VAL ((i == CH_PER) ? PER_INIT : CMP_INIT)
        ) u_shadow (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (sh_wr[i]),
            .wdata  (sh_wdata[i]),
            .load   (sh_ld[i]),
            .active (sh_act[i]),
            .valid  (sh_vld[i])
        );
    end

    assign per_valid = sh_vld[CH_PER];
    assign cmp_valid = sh_vld[CH_CMP];

    dbuf_timer_count #(
        .W (W)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .dual_slope (dual_slope),
        .cnt_wr     (cnt_wr),
        .cnt_data   (cnt_data),
        .restart    (restart),
        .per        (sh_act[CH_PER]),
        .cmp        (sh_act[CH_CMP]),
        .count      (count),
        .bottom_evt (bottom_evt),
        .match_evt  (match_evt),
        .ovf        (ovf)
    );

    dbuf_timer_wave u_wave (
        .clk        (clk),
        .rst_n      (rst_n),
        .dual_slope (dual_slope),
        .bottom_evt (bottom_evt),
        .match_evt  (match_evt),
        .wave       (wave)
    );

endmodule

// File: rtl/dbuf_timer_chk.sv
// Module: assertion checker bound to dbuf_timer; observes ports only.
// Assumes: synchronous active-low reset; properties are disabled in reset.
module dbuf_timer_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run,
    input logic         dual_slope,
    input logic         per_buf_wr,
    input logic         cmp_buf_wr,
    input logic         upd_cmd,
    input logic         cnt_wr,
    input logic [W-1:0] cnt_data,
    input logic         restart,
    input logic [W-1:0] count,
    input logic         ovf,
    input logic         wave,
    input logic         per_valid,
    input logic         cmp_valid
);

    // R6: direct write lands on the next cycle.
    a_r6_wr_priority: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count == $past(cnt_data)));

    // R6: a direct-write edge never produces an overflow.
    a_r6_wr_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> !ovf);

    // R7: restart clears the counter.
    a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !cnt_wr) |=> (count == '0));

    // R2: a buffer write raises its valid flag.
    a_r2_per_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
        per_buf_wr |=> per_valid);

    a_r2_cmp_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_buf_wr |=> cmp_valid);

    // R8: the update command drains the period flag and spares the compare flag.
    a_r8_upd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_cmd && !per_buf_wr) |=> !per_valid);

    a_r8_upd_keeps_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_cmd && !run && cmp_valid) |=> cmp_valid);

    // R3: in single-slope, an overflow cycle shows count zero.
    a_r3_ovf_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !$past(dual_slope)) |-> (count == '0));

    // R4: in dual-slope counting, steps are +1, -1 or a hold at zero.
    a_r4_dual_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dual_slope && !cnt_wr && !restart) |=>
        ((count == $past(count) + W'(1)) || (count == $past(count) - W'(1)) ||
         ((count == '0) && ($past(count) == '0))));

    // R11: idle keeps count and wave, and gives no overflow.
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr && !restart) |=> ($stable(count) && $stable(wave) && !ovf));

endmodule

bind dbuf_timer dbuf_timer_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .dual_slope (dual_slope),
    .per_buf_wr (per_buf_wr),
    .cmp_buf_wr (cmp_buf_wr),
    .upd_cmd    (upd_cmd),
    .cnt_wr     (cnt_wr),
    .cnt_data   (cnt_data),
    .restart    (restart),
    .count      (count),
    .ovf        (ovf),
    .wave       (wave),
    .per_valid  (per_valid),
    .cmp_valid  (cmp_valid)
);

// File: tb/dbuf_timer_bench.sv
// Bench: sweeps period/compare pairs in both modes and checks each cycle
// against arithmetic ramps, then runs directed priority and buffer cases.
module dbuf_timer_bench;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         run;
    logic         dual_slope;
    logic         per_buf_wr;
    logic [W-1:0] per_buf_data;
    logic         cmp_buf_wr;
    logic [W-1:0] cmp_buf_data;
    logic         upd_cmd;
    logic         cnt_wr;
    logic [W-1:0] cnt_data;
    logic         restart;
    logic [W-1:0] count;
    logic         ovf;
    logic         wave;
    logic         per_valid;
    logic         cmp_valid;

    int vectors     = 0;
    int miscompares = 0;
    bit done        = 1'b0;

    always #4 clk = ~clk;

    dbuf_timer #(.W(W)) u_dbuf_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run),
        .dual_slope   (dual_slope),
        .per_buf_wr   (per_buf_wr),
        .per_buf_data (per_buf_data),
        .cmp_buf_wr   (cmp_buf_wr),
        .cmp_buf_data (cmp_buf_data),
        .upd_cmd      (upd_cmd),
        .cnt_wr       (cnt_wr),
        .cnt_data     (cnt_data),
        .restart      (restart),
        .count        (count),
        .ovf          (ovf),
        .wave         (wave),
        .per_valid    (per_valid),
        .cmp_valid    (cmp_valid)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        run = 1'b0; per_buf_wr = 1'b0; per_buf_data = '0;
        cmp_buf_wr = 1'b0; cmp_buf_data = '0; upd_cmd = 1'b0;
        cnt_wr = 1'b0; cnt_data = '0; restart = 1'b0;
    endtask

    task automatic nedge();
        @(negedge clk);
    endtask

    task automatic do_reset();
        nedge();
        rst_n = 1'b0; dual_slope = 1'b0;
        idle_inputs();
        nedge();
        nedge();
        rst_n = 1'b1;
    endtask

    // Load period p and compare c, then wrap once in single-slope so that
    // the compare takes effect. Leaves count 0, wave 0, at step 0.
    task automatic setup(input int p, input int c, input logic dual_m);
        do_reset();
        per_buf_wr = 1'b1; per_buf_data = W'(p);
        cmp_buf_wr = 1'b1; cmp_buf_data = W'(c);
        nedge();
        per_buf_wr = 1'b0; cmp_buf_wr = 1'b0; upd_cmd = 1'b1;
        nedge();
        upd_cmd = 1'b0; cnt_wr = 1'b1; cnt_data = W'(p);
        nedge();
        cnt_wr = 1'b0; run = 1'b1;
        nedge();
        dual_slope = dual_m;
    endtask

    function automatic int dual_ref(input int k, input int p);
        int m;
        if (p == 0) return 0;
        m = k % (2 * p);
        return (m <= p) ? m : (2 * p - m);
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; dual_slope = 1'b0;
        idle_inputs();

        // R1: reset state and reset values of the active registers.
        do_reset();
        nedge();
        chk("R1 count", count, 0);
        chk("R1 ovf", ovf, 0);
        chk("R1 wave", wave, 0);
        chk("R1 per_valid", per_valid, 0);
        chk("R1 cmp_valid", cmp_valid, 0);
        cnt_wr = 1'b1; cnt_data = 16'hFFFE;
        nedge();
        cnt_wr = 1'b0; run = 1'b1;
        nedge();
        chk("R1 count reaches 0xFFFF", count, 16'hFFFF);
        nedge();
        chk("R1 wrap after 0xFFFF", count, 0);
        chk("R1 ovf at wrap", ovf, 1);
        chk("R1 wave clear at wrap", wave, 0);
        nedge();
        chk("R1 compare 0 sets wave", wave, 1);

        // R3 / R9 / R5: single-slope sweep.
        for (int p = 0; p <= 7; p++) begin
            for (int c = 0; c <= 9; c++) begin
                setup(p, c, 1'b0);
                chk("R5 per_valid drained", per_valid, 0);
                chk("R5 cmp_valid drained", cmp_valid, 0);
                for (int k = 0; k <= 3 * (p + 1) + 1; k++) begin
                    int ec;
                    ec = k % (p + 1);
                    chk($sformatf("R3 count p=%0d c=%0d k=%0d", p, c, k), count, ec);
                    chk($sformatf("R3 ovf p=%0d c=%0d k=%0d", p, c, k), ovf, (ec == 0) ? 1 : 0);
                    chk($sformatf("R9 wave p=%0d c=%0d k=%0d", p, c, k), wave, (ec > c) ? 1 : 0);
                    nedge();
                end
            end
        end

        // R4 / R10: dual-slope sweep including period 0.
        for (int p = 0; p <= 6; p++) begin
            for (int c = 0; c <= p + 1; c++) begin
                logic par;
                setup(p, c, 1'b1);
                par = 1'b0;
                for (int k = 0; k <= 4 * p + 3; k++) begin
                    int ec;
                    int eo;
                    ec = dual_ref(k, p);
                    eo = (p == 0 || k == 0 || (k > 2 * p && (k % (2 * p)) == 1)) ? 1 : 0;
                    chk($sformatf("R4 count p=%0d c=%0d k=%0d", p, c, k), count, ec);
                    chk($sformatf("R4 ovf p=%0d c=%0d k=%0d", p, c, k), ovf, eo);
                    chk($sformatf("R10 wave p=%0d c=%0d k=%0d", p, c, k), wave, par);
                    if (ec == c) par = !par;
                    nedge();
                end
            end
        end

        // R2: write on the same edge as a transfer.
        setup(3, 1, 1'b0);
        per_buf_wr = 1'b1; per_buf_data = 16'd5;
        nedge();
        per_buf_wr = 1'b0;
        chk("R2 per_valid set by write", per_valid, 1);
        nedge();
        nedge();
        chk("R2 count at old top", count, 3);
        per_buf_wr = 1'b1; per_buf_data = 16'd7;
        nedge();
        per_buf_wr = 1'b0;
        chk("R2 wrap count", count, 0);
        chk("R2 wrap ovf", ovf, 1);
        chk("R2 valid kept by same-edge write", per_valid, 1);
        repeat (5) nedge();
        chk("R2 period 5 reached", count, 5);
        nedge();
        chk("R2 wrap after 5", count, 0);
        chk("R2 valid cleared by transfer", per_valid, 0);
        repeat (7) nedge();
        chk("R2 period 7 reached", count, 7);
        nedge();
        chk("R5 wrap after 7", count, 0);

        // R6: direct write beats restart and the wrap; no transfer.
        per_buf_wr = 1'b1; per_buf_data = 16'd2;
        nedge();
        per_buf_wr = 1'b0;
        repeat (6) nedge();
        chk("R6 at top before write", count, 7);
        cnt_wr = 1'b1; cnt_data = 16'd4; restart = 1'b1;
        nedge();
        cnt_wr = 1'b0; restart = 1'b0;
        chk("R6 count takes written value", count, 4);
        chk("R6 no ovf", ovf, 0);
        chk("R6 no transfer", per_valid, 1);
        repeat (3) nedge();
        chk("R6 old period still active", count, 7);
        nedge();
        chk("R5 wrap loads pending period", count, 0);
        chk("R5 valid drained", per_valid, 0);
        repeat (2) nedge();
        chk("R5 new period 2 top", count, 2);
        nedge();
        chk("R5 new period 2 wraps", count, 0);

        // R7: restart while ramping down.
        setup(5, 9, 1'b1);
        repeat (7) nedge();
        chk("R7 ramping down", count, 3);
        restart = 1'b1;
        nedge();
        restart = 1'b0;
        chk("R7 restart clears", count, 0);
        nedge();
        chk("R7 counts up after restart", count, 1);
        nedge();
        chk("R7 still upward", count, 2);

        // R11 / R8: idle hold, then immediate period update.
        run = 1'b0;
        per_buf_wr = 1'b1; per_buf_data = 16'd3;
        cmp_buf_wr = 1'b1; cmp_buf_data = 16'd4;
        nedge();
        per_buf_wr = 1'b0; cmp_buf_wr = 1'b0;
        chk("R11 count held", count, 2);
        chk("R11 no ovf", ovf, 0);
        chk("R11 wave held", wave, 0);
        upd_cmd = 1'b1;
        nedge();
        upd_cmd = 1'b0;
        chk("R8 per_valid cleared", per_valid, 0);
        chk("R8 cmp_valid kept", cmp_valid, 1);
        chk("R11 count still held", count, 2);
        run = 1'b1;
        nedge();
        chk("R8 new period top", count, 3);
        nedge();
        chk("R8 turns at new period", count, 2);
        chk("R8 compare untouched", cmp_valid, 1);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule